// File: doc/BRIEF.md
# Packed Halfword Saturating Subtractor

This execute unit treats each 32-bit operand as two independent 16-bit lanes. For every lane it subtracts the second operand's lane from the first one's and clamps the difference to the signed or the unsigned 16-bit range. The instruction variant chooses the range. No borrow passes from the lower lane into the upper one.

The unit decodes a 32-bit register-register instruction word. It drives the two source register indices combinationally, so the register file can return the operand values in the same cycle. One clock edge later it presents the clamped result, the destination index and a one-cycle write-enable.

It also keeps four status flags. Overflow and advanced overflow are rewritten by every executed instruction. Their sticky copies only ever gain a 1 until reset. The unit holds no carry flag and never alters one.

Top module: `pk_sub_sat`

## Requirements
- R1: Each 16-bit lane result is the first operand's lane minus the second operand's lane (upper lane from bits 31:16, lower from bits 15:0), with no borrow passed between lanes.
- R2: With the signed variant (secondary opcode 0x6A), a lane whose exact difference exceeds 0x7FFF reads 0x7FFF, and one below -0x8000 reads 0x8000.
- R3: With the unsigned variant (secondary opcode 0x6B), a lane whose exact difference is negative reads 0x0000; otherwise it reads the plain difference.
- R4: `flagV` becomes 1 after an executed instruction in which either lane left its selected range, and 0 after one in which neither did.
- R5: `flagSV` becomes 1 whenever `flagV` is set and otherwise keeps its value, so it never falls outside reset.
- R6: `flagAV` becomes, on every executed instruction, the OR over both lanes of bit 15 XOR bit 14 of that lane's unclamped 16-bit difference.
- R7: `flagSAV` becomes 1 whenever `flagAV` is set and otherwise keeps its value.
- R8: An instruction executes only when `instValid` is high, bits 7:0 equal 0x0B and bits 27:20 equal 0x6A or 0x6B. `srcAIdx` is bits 11:8, `srcBIdx` is bits 15:12 and `dstIdx` comes from bits 31:28. Bits 19:16 have no effect.
- R9: A cycle with `instValid` low, or with a word that matches neither encoding, produces no write and leaves all four flags unchanged.
- R10: `resWe`, `resData` and `dstIdx` for an instruction presented at one rising edge appear after that edge and stay valid for one cycle. `resWe` is a single-cycle pulse for each executed instruction.
- R11: A synchronous reset clears `resWe` and all four flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | Instruction word is valid this cycle |
| instWord | input | 32 | Instruction word |
| opA | input | 32 | Register value read at `srcAIdx` |
| opB | input | 32 | Register value read at `srcBIdx` |
| srcAIdx | output | 4 | First source register index (combinational) |
| srcBIdx | output | 4 | Second source register index (combinational) |
| resWe | output | 1 | Destination write-enable, one cycle |
| dstIdx | output | 4 | Destination register index |
| resData | output | 32 | Packed clamped result |
| flagV | output | 1 | Overflow of the last executed instruction |
| flagSV | output | 1 | Sticky overflow |
| flagAV | output | 1 | Advanced overflow of the last executed instruction |
| flagSAV | output | 1 | Sticky advanced overflow |

## Verification
The source indices are combinational, so the bench checks them in the same cycle the word is driven. Every other result (`resWe`, `resData`, `dstIdx` and the four flags) is registered once and is due exactly one rising edge after the stimulus. Each task drives its inputs on a falling edge, waits for one rising edge and samples on the following falling edge. One more cycle with no valid instruction then shows that `resWe` has dropped and that the flags held their values.

// File: rtl/pk_sub_pkg.sv
package pk_sub_pkg;
  localparam int INST_W = 32;
  localparam int IDX_W = 4;
  localparam logic [7:0] MAJOR_OP = 8'h0B;
  localparam logic [7:0] SUB_SIGNED = 8'h6A;
  localparam logic [7:0] SUB_UNSIGNED = 8'h6B;

  typedef struct packed {
    logic fire;
    logic useUnsigned;
  } subCtrl_t;
endpackage

// File: rtl/pk_sub_ctrl.sv
module pk_sub_ctrl
  import pk_sub_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              instValid,
  input  logic [INST_W-1:0] instWord,
  output logic [IDX_W-1:0]  srcAIdx,
  output logic [IDX_W-1:0]  srcBIdx,
  output logic [IDX_W-1:0]  dstIdx,
  output subCtrl_t          ctrl
);
  logic [7:0] majorField;
  logic [7:0] minorField;
  logic       isSigned;
  logic       isUnsigned;
  logic       unusedSpare;

  assign majorField = instWord[7:0];
  assign minorField = instWord[27:20];
  assign srcAIdx = instWord[11:8];
  assign srcBIdx = instWord[15:12];
  assign unusedSpare = ^instWord[19:16];

  assign isSigned = (minorField == SUB_SIGNED);
  assign isUnsigned = (minorField == SUB_UNSIGNED);

  always_comb begin
    ctrl.fire = instValid && (majorField == MAJOR_OP) && (isSigned || isUnsigned);
    ctrl.useUnsigned = isUnsigned;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dstIdx <= '0;
    end else if (ctrl.fire) begin
      dstIdx <= instWord[31:28];
    end
  end
endmodule

// File: rtl/pk_sub_dp.sv
module pk_sub_dp
  import pk_sub_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int NUM_LANES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  subCtrl_t                    ctrl,
  input  logic [LANE_W*NUM_LANES-1:0] opA,
  input  logic [LANE_W*NUM_LANES-1:0] opB,
  output logic [LANE_W*NUM_LANES-1:0] resData,
  output logic                        resWe,
  output logic                        anyOv,
  output logic                        anyAov
);
  localparam int DATA_W = LANE_W * NUM_LANES;
  localparam logic [LANE_W-1:0] SMAX = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] SMIN = {1'b1, {(LANE_W-1){1'b0}}};

  logic [DATA_W-1:0]    clamped;
  logic [NUM_LANES-1:0] laneOv;
  logic [NUM_LANES-1:0] laneAov;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [LANE_W-1:0] aPart;
    logic [LANE_W-1:0] bPart;
    logic [LANE_W:0]   extA;
    logic [LANE_W:0]   extB;
    logic [LANE_W:0]   diff;
    logic [LANE_W-1:0] raw;
    logic              ovHere;

    assign aPart = opA[l*LANE_W +: LANE_W];
    assign bPart = opB[l*LANE_W +: LANE_W];
    assign extA = {ctrl.useUnsigned ? 1'b0 : aPart[LANE_W-1], aPart};
    assign extB = {ctrl.useUnsigned ? 1'b0 : bPart[LANE_W-1], bPart};
    assign diff = extA - extB;
    assign raw = diff[LANE_W-1:0];

    always_comb begin
      if (ctrl.useUnsigned) begin
        ovHere = diff[LANE_W];
        clamped[l*LANE_W +: LANE_W] = ovHere ? '0 : raw;
      end else begin
        ovHere = diff[LANE_W] ^ diff[LANE_W-1];
        if (!ovHere) begin
          clamped[l*LANE_W +: LANE_W] = raw;
        end else if (diff[LANE_W]) begin
          clamped[l*LANE_W +: LANE_W] = SMIN;
        end else begin
          clamped[l*LANE_W +: LANE_W] = SMAX;
        end
      end
    end

    assign laneOv[l] = ovHere;
    assign laneAov[l] = raw[LANE_W-1] ^ raw[LANE_W-2];
  end

  assign anyOv = |laneOv;
  assign anyAov = |laneAov;

  always_ff @(posedge clk) begin
    if (rst) begin
      resWe <= 1'b0;
      resData <= '0;
    end else begin
      resWe <= ctrl.fire;
      if (ctrl.fire) begin
        resData <= clamped;
      end
    end
  end
endmodule

// File: rtl/pk_sub_flags.sv
module pk_sub_flags (
  input  logic clk,
  input  logic rst,
  input  logic update,
  input  logic ovIn,
  input  logic aovIn,
  output logic flagV,
  output logic flagSV,
  output logic flagAV,
  output logic flagSAV
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flagV <= 1'b0;
      flagSV <= 1'b0;
      flagAV <= 1'b0;
      flagSAV <= 1'b0;
    end else if (update) begin
      flagV <= ovIn;
      flagSV <= flagSV | ovIn;
      flagAV <= aovIn;
      flagSAV <= flagSAV | aovIn;
    end
  end
endmodule

// File: rtl/pk_sub_sat.sv
module pk_sub_sat
  import pk_sub_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int NUM_LANES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        instValid,
  input  logic [31:0]                 instWord,
  input  logic [LANE_W*NUM_LANES-1:0] opA,
  input  logic [LANE_W*NUM_LANES-1:0] opB,
  output logic [3:0]                  srcAIdx,
  output logic [3:0]                  srcBIdx,
  output logic                        resWe,
  output logic [3:0]                  dstIdx,
  output logic [LANE_W*NUM_LANES-1:0] resData,
  output logic                        flagV,
  output logic                        flagSV,
  output logic                        flagAV,
  output logic                        flagSAV
);
  subCtrl_t ctrl;
  logic     anyOv;
  logic     anyAov;

  pk_sub_ctrl u_ctrl (
    .clk(clk), .rst(rst), .instValid(instValid), .instWord(instWord),
    .srcAIdx(srcAIdx), .srcBIdx(srcBIdx), .dstIdx(dstIdx), .ctrl(ctrl)
  );

  pk_sub_dp #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .opA(opA), .opB(opB),
    .resData(resData), .resWe(resWe), .anyOv(anyOv), .anyAov(anyAov)
  );

  pk_sub_flags u_flags (
    .clk(clk), .rst(rst), .update(ctrl.fire), .ovIn(anyOv), .aovIn(anyAov),
    .flagV(flagV), .flagSV(flagSV), .flagAV(flagAV), .flagSAV(flagSAV)
  );
endmodule

// File: rtl/pk_sub_sat_chk.sv
module pk_sub_sat_chk (
  input logic        clk,
  input logic        rst,
  input logic        instValid,
  input logic [31:0] instWord,
  input logic        resWe,
  input logic        flagV,
  input logic        flagSV,
  input logic        flagAV,
  input logic        flagSAV
);
  logic wordOk;
  assign wordOk = instValid && (instWord[7:0] == 8'h0B) &&
                  ((instWord[27:20] == 8'h6A) || (instWord[27:20] == 8'h6B));

  // R10: write pulse follows an accepted word by one edge
  assert_we_follows_R10: assert property (@(posedge clk) disable iff (rst)
    wordOk |=> resWe);
  // R9: no accepted word, no write and flags hold
  assert_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    !wordOk |=> !resWe);
  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !wordOk |=> $stable({flagV, flagSV, flagAV, flagSAV}));
  // R5: sticky overflow never drops and covers V
  assert_sv_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    !$fell(flagSV));
  assert_sv_covers_R5: assert property (@(posedge clk) disable iff (rst)
    flagV |-> flagSV);
  // R7: sticky advanced overflow never drops and covers AV
  assert_sav_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    !$fell(flagSAV));
  assert_sav_covers_R7: assert property (@(posedge clk) disable iff (rst)
    flagAV |-> flagSAV);
  // R11: reset clears outputs on the next edge
  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (!resWe && !flagV && !flagSV && !flagAV && !flagSAV));
endmodule

bind pk_sub_sat pk_sub_sat_chk u_chk (
  .clk(clk), .rst(rst), .instValid(instValid), .instWord(instWord),
  .resWe(resWe), .flagV(flagV), .flagSV(flagSV), .flagAV(flagAV),
  .flagSAV(flagSAV)
);

// File: tb/pk_sub_sat_bench.sv
`timescale 1ns/1ps
module pk_sub_sat_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [3:0]  srcAIdx, srcBIdx, dstIdx;
  logic        resWe, flagV, flagSV, flagAV, flagSAV;
  logic [31:0] resData;

  int checks = 0;
  int failures = 0;
  logic expSV = 1'b0;
  logic expSAV = 1'b0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  pk_sub_sat u_pk_sub_sat (
    .clk(clk), .rst(rst), .instValid(instValid), .instWord(instWord),
    .opA(opA), .opB(opB), .srcAIdx(srcAIdx), .srcBIdx(srcBIdx),
    .resWe(resWe), .dstIdx(dstIdx), .resData(resData), .flagV(flagV),
    .flagSV(flagSV), .flagAV(flagAV), .flagSAV(flagSAV)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkWord(logic [7:0] minor, logic [3:0] a,
                                         logic [3:0] b, logic [3:0] c,
                                         logic [3:0] spare);
    return {c, minor, spare, b, a, 8'h0B};
  endfunction

  // returns {aov, ov, result}
  function automatic logic [33:0] model(logic [31:0] a, logic [31:0] b, bit uns);
    logic [31:0] res;
    logic ov, aov;
    ov = 1'b0;
    aov = 1'b0;
    for (int l = 0; l < 2; l++) begin
      logic [15:0] la, lb, raw, outv;
      int x;
      la = a[16*l +: 16];
      lb = b[16*l +: 16];
      if (uns) x = int'(la) - int'(lb);
      else     x = int'($signed(la)) - int'($signed(lb));
      raw = x[15:0];
      aov |= raw[15] ^ raw[14];
      if (uns) begin
        if (x < 0) begin outv = 16'h0000; ov = 1'b1; end
        else outv = raw;
      end else begin
        if (x > 32767) begin outv = 16'h7FFF; ov = 1'b1; end
        else if (x < -32768) begin outv = 16'h8000; ov = 1'b1; end
        else outv = raw;
      end
      res[16*l +: 16] = outv;
    end
    return {aov, ov, res};
  endfunction

  task automatic idleCycle();
    @(negedge clk);
    instValid = 1'b0;
    instWord = 32'h0;
  endtask

  task automatic runOp(string req, logic [31:0] a, logic [31:0] b, bit uns,
                       logic [3:0] dst);
    logic [33:0] m;
    m = model(a, b, uns);
    @(negedge clk);
    instValid = 1'b1;
    instWord = mkWord(uns ? 8'h6B : 8'h6A, 4'd3, 4'd5, dst, 4'hA);
    opA = a;
    opB = b;
    @(posedge clk);
    @(negedge clk);
    instValid = 1'b0;
    expSV = expSV | m[32];
    expSAV = expSAV | m[33];
    chk({req, " R1 data"}, resData, m[31:0]);
    chk("R10 resWe", {31'b0, resWe}, 32'd1);
    chk("R8 dstIdx", {28'b0, dstIdx}, {28'b0, dst});
    chk("R4 flagV", {31'b0, flagV}, {31'b0, m[32]});
    chk("R6 flagAV", {31'b0, flagAV}, {31'b0, m[33]});
    chk("R5 flagSV", {31'b0, flagSV}, {31'b0, expSV});
    chk("R7 flagSAV", {31'b0, flagSAV}, {31'b0, expSAV});
  endtask

  task automatic tReset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    expSV = 1'b0;
    expSAV = 1'b0;
    chk("R11 resWe", {31'b0, resWe}, 32'd0);
    chk("R11 flags", {28'b0, flagV, flagSV, flagAV, flagSAV}, 32'd0);
  endtask

  task automatic tCorners();
    runOp("R2 min-1", 32'h8000_8000, 32'h0001_0001, 1'b0, 4'd1);
    chk("R2 clamp low", resData, 32'h8000_8000);
    runOp("R2 max-neg", 32'h7FFF_0005, 32'hFFFF_0003, 1'b0, 4'd2);
    chk("R2 clamp high", resData, 32'h7FFF_0002);
    runOp("R3 0-1", 32'h0000_0005, 32'h0001_0003, 1'b1, 4'd4);
    chk("R3 clamp zero", resData, 32'h0000_0002);
    runOp("R3 max-neg", 32'h7FFF_FFFF, 32'hFFFF_0001, 1'b1, 4'd6);
    chk("R3 unsigned lanes", resData, 32'h0000_FFFE);
    runOp("R1 equal", 32'h1234_ABCD, 32'h1234_ABCD, 1'b0, 4'd7);
    chk("R1 equal zero", resData, 32'h0000_0000);
    runOp("R1 noborrow", 32'h0005_0000, 32'h0001_0001, 1'b1, 4'd8);
    chk("R1 lane isolation", resData, 32'h0004_0000);
    idleCycle();
    chk("R10 pulse drop", {31'b0, resWe}, 32'd0);
  endtask

  task automatic tSticky();
    tReset();
    runOp("R4 ov", 32'h8000_0000, 32'h0001_0000, 1'b0, 4'd9);
    chk("R5 set", {31'b0, flagSV}, 32'd1);
    runOp("R4 clear", 32'h0010_0010, 32'h0001_0001, 1'b0, 4'd9);
    chk("R4 V cleared", {31'b0, flagV}, 32'd0);
    chk("R5 SV persists", {31'b0, flagSV}, 32'd1);
    chk("R6 AV cleared", {31'b0, flagAV}, 32'd0);
    chk("R7 SAV persists", {31'b0, flagSAV}, 32'd1);
    // AV without V: 0x4000 - 0 in lane gives bit15^bit14 = 1, no overflow
    tReset();
    runOp("R6 aov only", 32'h0000_4000, 32'h0000_0000, 1'b0, 4'd10);
    chk("R6 AV set", {31'b0, flagAV}, 32'd1);
    chk("R4 V clear", {31'b0, flagV}, 32'd0);
    chk("R5 SV clear", {31'b0, flagSV}, 32'd0);
  endtask

  task automatic tIgnore();
    tReset();
    runOp("R9 prep", 32'h8000_4000, 32'h0001_0000, 1'b0, 4'd11);
    // valid low with a matching word
    @(negedge clk);
    instValid = 1'b0;
    instWord = mkWord(8'h6A, 4'd1, 4'd2, 4'd3, 4'h0);
    opA = 32'h0001_0001;
    opB = 32'h0001_0001;
    @(posedge clk);
    @(negedge clk);
    chk("R9 no we (valid low)", {31'b0, resWe}, 32'd0);
    chk("R9 flags hold", {28'b0, flagV, flagSV, flagAV, flagSAV}, 32'hF);
    chk("R9 data hold", resData, model(32'h8000_4000, 32'h0001_0000, 1'b0));
    // bad secondary opcode
    instValid = 1'b1;
    instWord = mkWord(8'h6C, 4'd1, 4'd2, 4'd3, 4'h0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 no we (bad minor)", {31'b0, resWe}, 32'd0);
    chk("R9 flags hold minor", {28'b0, flagV, flagSV, flagAV, flagSAV}, 32'hF);
    // bad major opcode
    instWord = mkWord(8'h6A, 4'd1, 4'd2, 4'd3, 4'h0) ^ 32'h0000_0001;
    @(posedge clk);
    @(negedge clk);
    chk("R9 no we (bad major)", {31'b0, resWe}, 32'd0);
    chk("R9 flags hold major", {28'b0, flagV, flagSV, flagAV, flagSAV}, 32'hF);
    instValid = 1'b0;
  endtask

  task automatic tDecode();
    @(negedge clk);
    instValid = 1'b1;
    instWord = mkWord(8'h6B, 4'hC, 4'h6, 4'hE, 4'hF);
    opA = 32'h0009_0009;
    opB = 32'h0002_0003;
    #1;
    chk("R8 srcA", {28'b0, srcAIdx}, 32'hC);
    chk("R8 srcB", {28'b0, srcBIdx}, 32'h6);
    @(posedge clk);
    @(negedge clk);
    instValid = 1'b0;
    chk("R8 spare bits ignored we", {31'b0, resWe}, 32'd1);
    chk("R8 spare bits ignored data", resData, 32'h0007_0006);
    chk("R8 dst", {28'b0, dstIdx}, 32'hE);
  endtask

  task automatic tRandom();
    for (int i = 0; i < 60; i++) begin
      logic [31:0] a, b;
      a = $urandom();
      b = $urandom();
      if (i % 4 == 0) b[15:0] = a[15:0] ^ 16'h8000;
      runOp(i % 2 ? "R3 rand" : "R2 rand", a, b, bit'(i % 2), 4'(i));
    end
  endtask

  initial begin
    tReset();
    tCorners();
    tSticky();
    tIgnore();
    tDecode();
    tReset();
    tRandom();
    idleCycle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule